// File: doc/BRIEF.md
# Resettable Stereo Sample FIFO

This block buffers stereo audio samples between a register write port and a serial audio transmitter. Each entry is one sample of 40 bits (left and right halves together). The transmitter asks for a sample with a one-cycle request and finds the value on the read bus in the next cycle. The bus keeps that value until the next request.

The block does not come out of reset empty. While the control reset bit is set, it holds one all-zero sample ready to read, and reads do not use that sample up. When the reset bit is cleared, the block stays armed in this state until the first sample is written. That write starts normal operation and is queued behind the pending zero. Two interfaces at the same sample rate that are started this way stay a fixed number of samples apart.

A source code that the block captures during reset can replace every output sample with digital zero. In that mode the block never raises an underrun or overrun flag.

Top module: `audio_sample_fifo`

## Requirements
- R1: While `ctl_hold` is 1, a cycle with `rd_req` set puts zero on `rd_data` in the next cycle and consumes nothing, so one zero sample always stays pending.
- R2: After `ctl_hold` falls, reads return zero without consuming until the first cycle with `wr_valid`. That write is stored behind the pending zero sample, and normal operation starts in the next cycle.
- R3: In normal operation, samples leave in the order written. `rd_data` changes only in the cycle after a cycle with `rd_req`, and otherwise keeps its value.
- R4: A read while the FIFO holds no entry leaves `rd_data` unchanged and sets `underrun`. The flag stays set until the block re-enters reset.
- R5: A write while 8 entries are held is dropped and sets `overrun`, which stays set until reset. Fullness is judged before a read in the same cycle.
- R6: Source code 2'b01 selects digital zero. Every read then returns zero and still consumes an entry if one is held, and neither flag is ever set. Any other code selects FIFO data.
- R7: The source code is captured only while `ctl_hold` is 1. Changes to `ctl_src` during normal operation have no effect.
- R8: Entering reset discards all held samples, leaves one zero sample pending, and clears both flags in the next cycle.
- R9: Writes made while `ctl_hold` is 1 are ignored.
- R10: After the asynchronous `rst_n` the block behaves as if in reset: `rd_data` is zero, both flags are clear, FIFO data is selected, and one zero sample is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_hold | input | 1 | Control reset bit |
| ctl_src | input | 2 | Source code, 2'b01 selects digital zero |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | 40 | Sample to write |
| rd_req | input | 1 | Read request from the serial engine |
| rd_data | output | 40 | Sample returned, valid the cycle after a request |
| underrun | output | 1 | Sticky read-while-empty flag |
| overrun | output | 1 | Sticky write-while-full flag |

## Verification
The FIFO is driven with single writes and reads, with bursts that interleave writes and reads, and with writes and reads in the same cycle at empty and at full. These patterns separate queue ordering from the full and empty limits. Reads made while held and while armed show whether the pending zero sample is counted once or is consumed. A write made at the moment the block arms shows whether that write is queued behind the zero sample. Runs with the zero source are compared with the same stimulus under the data source, which shows that zero replaces the data while the entries are still consumed and the flags stay clear.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } fifo_mode_e;

    localparam int SRC_W = 2;
    localparam logic [SRC_W-1:0] SRC_ZERO = 2'b01;
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int DATA_W = 40,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
    import afifo_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = 3,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_hold,
    input  logic [SRC_W-1:0]  ctl_src,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [PTR_W-1:0]  mem_raddr,
    output logic [DATA_W-1:0] rd_data,
    output logic              underrun,
    output logic              overrun,
    output logic              src_zero,
    output logic [LVL_W-1:0]  level
);
    typedef struct packed {
        fifo_mode_e        mode;
        logic [PTR_W-1:0]  rptr;
        logic [PTR_W-1:0]  wptr;
        logic [LVL_W-1:0]  level;
        logic              zero_src;
        logic              ur;
        logic              ov;
        logic [DATA_W-1:0] out;
    } ctl_t;

    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    ctl_t ctl_d, ctl_q;
    logic push, pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        ctl_d     = ctl_q;
        mem_we    = 1'b0;
        mem_waddr = ctl_q.wptr;
        mem_wdata = wr_data;
        mem_raddr = ctl_q.rptr;
        push      = 1'b0;
        pop       = 1'b0;

        if (ctl_hold) begin
            // reset image: slot 0 cleared and pending, flags dropped
            ctl_d.mode     = ST_HOLD;
            ctl_d.rptr     = '0;
            ctl_d.wptr     = PTR_W'(1);
            ctl_d.level    = LVL_W'(1);
            ctl_d.zero_src = (ctl_src == SRC_ZERO);
            ctl_d.ur       = 1'b0;
            ctl_d.ov       = 1'b0;
            mem_we         = 1'b1;
            mem_waddr      = '0;
            mem_wdata      = '0;
            if (rd_req) ctl_d.out = '0;
        end else if (ctl_q.mode != ST_RUN) begin
            // armed: still in reset until the first write lands
            if (rd_req) ctl_d.out = '0;
            if (wr_valid) begin
                mem_we      = 1'b1;
                ctl_d.wptr  = ptr_inc(ctl_q.wptr);
                ctl_d.level = ctl_q.level + LVL_W'(1);
                ctl_d.mode  = ST_RUN;
            end else begin
                ctl_d.mode  = ST_ARMED;
            end
        end else begin
            pop  = rd_req   && (ctl_q.level != '0);
            push = wr_valid && (ctl_q.level != LVL_FULL);

            if (rd_req) begin
                if (pop) begin
                    ctl_d.out  = ctl_q.zero_src ? '0 : mem_rdata;
                    ctl_d.rptr = ptr_inc(ctl_q.rptr);
                end else if (ctl_q.zero_src) begin
                    ctl_d.out  = '0;
                end else begin
                    ctl_d.ur   = 1'b1;
                end
            end

            if (push) begin
                mem_we     = 1'b1;
                ctl_d.wptr = ptr_inc(ctl_q.wptr);
            end else if (wr_valid && !ctl_q.zero_src) begin
                ctl_d.ov   = 1'b1;
            end

            case ({push, pop})
                2'b10:   ctl_d.level = ctl_q.level + LVL_W'(1);
                2'b01:   ctl_d.level = ctl_q.level - LVL_W'(1);
                default: ctl_d.level = ctl_q.level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mode     <= ST_HOLD;
            ctl_q.rptr     <= '0;
            ctl_q.wptr     <= PTR_W'(1);
            ctl_q.level    <= LVL_W'(1);
            ctl_q.zero_src <= 1'b0;
            ctl_q.ur       <= 1'b0;
            ctl_q.ov       <= 1'b0;
            ctl_q.out      <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_data  = ctl_q.out;
    assign underrun = ctl_q.ur;
    assign overrun  = ctl_q.ov;
    assign src_zero = ctl_q.zero_src;
    assign level    = ctl_q.level;
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import afifo_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_hold,
    input  logic [1:0]        ctl_src,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              underrun,
    output logic              overrun
);
    localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic              mem_we;
    logic [PTR_W-1:0]  mem_waddr;
    logic [PTR_W-1:0]  mem_raddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              src_zero;
    logic [LVL_W-1:0]  level;

    afifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    afifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_hold  (ctl_hold),
        .ctl_src   (ctl_src),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .rd_data   (rd_data),
        .underrun  (underrun),
        .overrun   (overrun),
        .src_zero  (src_zero),
        .level     (level)
    );
endmodule

// File: rtl/afifo_checker.sv
module afifo_checker #(
    parameter int DATA_W = 40,
    parameter int DEPTH  = 8,
    parameter int LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_hold,
    input logic              rd_req,
    input logic [DATA_W-1:0] rd_data,
    input logic              underrun,
    input logic              overrun,
    input logic              src_zero,
    input logic [LVL_W-1:0]  level
);
    a_r1_hold_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hold && rd_req |=> rd_data == '0);

    a_r1_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hold |=> level == LVL_W'(1));

    a_r8_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hold |=> !underrun && !overrun);

    a_r3_out_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));

    a_r4_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hold && underrun |=> underrun);

    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hold && overrun |=> overrun);

    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    a_r6_zero_output: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hold && src_zero && rd_req |=> rd_data == '0);

    a_r6_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hold && src_zero |=> $stable(underrun) && $stable(overrun));

    a_r7_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hold |=> $stable(src_zero));
endmodule

bind audio_sample_fifo afifo_checker #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .LVL_W  (LVL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_hold (ctl_hold),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .underrun (underrun),
    .overrun  (overrun),
    .src_zero (src_zero),
    .level    (level)
);

// File: tb/sim_audio_sample_fifo.sv
`timescale 1ns/1ps
module sim_audio_sample_fifo;
    localparam int DW = 40;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_hold = 1'b0;
    logic [1:0]    ctl_src = 2'b00;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_req = 1'b0;
    logic [DW-1:0] rd_data;
    logic          underrun, overrun;

    int checks = 0;
    int fails = 0;
    string cur_req = "R10";

    // behavioural reference
    logic [DW-1:0] m_q[$];
    int            m_mode = 0;      // 0 held, 1 armed, 2 running
    bit            m_zero = 0;
    logic [DW-1:0] m_out = '0;
    bit            m_ur = 0, m_ov = 0;

    always #2 clk = ~clk;

    audio_sample_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_hold(ctl_hold), .ctl_src(ctl_src),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
        .rd_data(rd_data), .underrun(underrun), .overrun(overrun)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q = {}; m_q.push_back('0);
            m_mode = 0; m_zero = 0; m_out = '0; m_ur = 0; m_ov = 0;
        end else if (ctl_hold) begin
            m_q = {}; m_q.push_back('0);
            m_mode = 0; m_zero = (ctl_src == 2'b01); m_ur = 0; m_ov = 0;
            if (rd_req) m_out = '0;
        end else if (m_mode != 2) begin
            if (rd_req) m_out = '0;
            if (wr_valid) begin m_q.push_back(wr_data); m_mode = 2; end
            else m_mode = 1;
        end else begin
            int sz;
            logic [DW-1:0] v;
            sz = m_q.size();
            if (rd_req) begin
                if (sz > 0) begin v = m_q.pop_front(); m_out = m_zero ? '0 : v; end
                else if (m_zero) m_out = '0;
                else m_ur = 1;
            end
            if (wr_valid) begin
                if (sz < DEPTH) m_q.push_back(wr_data);
                else if (!m_zero) m_ov = 1;
            end
        end
    end

    task automatic compare();
        checks++;
        if (rd_data !== m_out || underrun !== m_ur || overrun !== m_ov) begin
            fails++;
            $display("FAIL %s: got data=%h ur=%b ov=%b, expected data=%h ur=%b ov=%b",
                     cur_req, rd_data, underrun, overrun, m_out, m_ur, m_ov);
        end
    endtask

    task automatic step(input logic h, input logic [1:0] s, input logic wv,
                        input logic [DW-1:0] wd, input logic rr);
        ctl_hold = h; ctl_src = s; wr_valid = wv; wr_data = wd; rd_req = rr;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        return {8'hA5, 32'(k * 32'h01010101 + 7)};
    endfunction

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R10"; compare();
        rst_n = 1'b1;
        step(0, 2'b00, 0, '0, 0);

        // R1 and R9: held, reads give zero, writes ignored
        cur_req = "R1";
        step(1, 2'b00, 0, '0, 1);
        step(1, 2'b00, 1, pat(90), 1);
        cur_req = "R9";
        step(1, 2'b00, 1, pat(91), 0);
        step(1, 2'b00, 0, '0, 1);

        // R2: armed, reads stay zero until the first write
        cur_req = "R2";
        step(0, 2'b00, 0, '0, 1);
        step(0, 2'b00, 0, '0, 1);
        step(0, 2'b00, 1, pat(1), 1);
        step(0, 2'b00, 0, '0, 1);   // pending zero
        step(0, 2'b00, 0, '0, 1);   // first written sample

        // R3: ordering with interleaved and simultaneous traffic
        cur_req = "R3";
        for (int k = 2; k < 6; k++) step(0, 2'b00, 1, pat(k), 0);
        step(0, 2'b00, 0, '0, 1);
        step(0, 2'b00, 1, pat(6), 1);
        step(0, 2'b00, 0, '0, 0);
        for (int k = 0; k < 4; k++) step(0, 2'b00, 0, '0, 1);

        // R4: empty reads
        cur_req = "R4";
        step(0, 2'b00, 0, '0, 1);
        step(0, 2'b00, 0, '0, 0);
        step(0, 2'b00, 1, pat(7), 1);
        step(0, 2'b00, 0, '0, 1);

        // R8: re-entering reset
        cur_req = "R8";
        step(0, 2'b00, 1, pat(8), 0);
        step(1, 2'b00, 0, '0, 0);
        step(0, 2'b00, 1, pat(9), 0);
        step(0, 2'b00, 0, '0, 1);
        step(0, 2'b00, 0, '0, 1);
        step(0, 2'b00, 0, '0, 1);

        // R5: filling past capacity
        cur_req = "R5";
        step(1, 2'b00, 0, '0, 0);
        step(0, 2'b00, 1, pat(10), 1);
        for (int k = 11; k < 20; k++) step(0, 2'b00, 1, pat(k), 0);
        step(0, 2'b00, 1, pat(20), 1);
        for (int k = 0; k < 10; k++) step(0, 2'b00, 0, '0, 1);

        // R6 and R7: zero source captured in reset, later code change ignored
        cur_req = "R6";
        step(1, 2'b01, 0, '0, 0);
        cur_req = "R7";
        step(0, 2'b00, 1, pat(30), 0);
        for (int k = 31; k < 41; k++) step(0, 2'b10, 1, pat(k), 0);
        cur_req = "R6";
        for (int k = 0; k < 11; k++) step(0, 2'b00, 0, '0, 1);
        step(0, 2'b00, 1, pat(42), 1);

        // R7: another non-zero code selects data again
        cur_req = "R7";
        step(1, 2'b10, 0, '0, 0);
        step(0, 2'b01, 1, pat(50), 0);
        step(0, 2'b01, 0, '0, 1);
        step(0, 2'b01, 0, '0, 1);
        step(0, 2'b00, 0, '0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule